// File: doc/BRIEF.md
# Key Event Queue

This block buffers key events from a keypad scanner until a host reads them. Each event is one byte. The top bit says whether the key went down (1) or came up (0), and the low seven bits carry the key number. Up to ten events are held in arrival order. An occupancy count shows the host how many events are waiting.

The host talks to the block through a simple register port: one strobe, a write flag, an address, write data and registered read data. Ten consecutive addresses all alias the same queue head. A read from any of them returns the oldest event and removes it from the queue. Other addresses hold a configuration byte, a status byte with two sticky flags, and the count. A configuration bit selects the behaviour when an event arrives at a full queue. The new event is either dropped, or written over the oldest stored entry.

The block raises two sticky flags. One records that an event was logged and the other records an overflow. Each flag has its own enable, and together they drive an active-low interrupt line. The host clears a flag by writing 1 to its bit.

Top module: `key_event_queue`

## Requirements
- R1: After reset the count reads 0, the configuration and status bytes read 0x00, and `irq_n` is 1.
- R2: A read from any address in 4..13 returns the oldest stored event byte (bit 7 = press, bits 6:0 = key) unchanged, and removes it, so that successive reads from any mix of these addresses return events in arrival order.
- R3: A read from the event window while the queue is empty returns 0x00, and the count stays 0.
- R4: A read of address 2 returns, in bits 3:0, the number of events held (0 to 10). The count rises by one for each event accepted into a non-full queue and falls by one for each event popped.
- R5: When the queue holds 10 events and configuration bit 2 is 0, an arriving event with no pop in the same cycle is discarded, and the stored contents and the count are unchanged.
- R6: When the queue holds 10 events and configuration bit 2 is 1, an arriving event with no pop in the same cycle replaces the oldest entry. The count stays 10, and reads return the oldest remaining events followed by the new one.
- R7: An event that arrives at a full queue with no pop in the same cycle sets status bit 1 (overflow). The bit stays set until the host writes 1 to bit 1 of address 1.
- R8: Status bit 0 (event logged) is set when an event is accepted while configuration bit 0 is 1. While that enable is 0, accepted events leave the bit unchanged. Writing 1 to bit 0 of address 1 clears it.
- R9: `irq_n` is 0 exactly when (status bit 0 and configuration bit 0) or (status bit 1 and configuration bit 1) is set.
- R10: An event write and an event-window read in the same cycle both take effect. The read returns the oldest event, the count is unchanged, and a full queue then takes the new event with no overflow.
- R11: Address 0 reads back the configuration byte in bits 2:0, with zeros above. Addresses 3 and 14 to 31 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | Scanner offers one event this cycle |
| ev_data | input | 8 | Event byte: bit 7 press/release, bits 6:0 key number |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, registered, valid after the edge that captured the read |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Read data is registered on the same clock edge that samples the access, so it is valid one edge after `acc_en` is presented. The same edge pops the queue and updates the count. Flags are updated on the edge that captures an event or a clear write, and `irq_n` follows them without further delay. The scoreboard therefore compares each read result 1 ns after the edge that captured the read. Interrupt checks are taken at the falling edge that follows the capturing edge. A reference queue kept in the bench supplies the expected bytes for every ordering case: drop, overwrite, and a pop in the same cycle as a write.

// File: rtl/kq_pkg.sv
package kq_pkg;
  // configuration byte, bits 2:0
  typedef struct packed {
    logic ovf_mode;   // bit 2: 0 drop newest, 1 overwrite oldest
    logic ovf_ie;     // bit 1
    logic evt_ie;     // bit 0
  } kq_cfg_t;

  localparam int unsigned CFG_W  = 3;
  localparam int unsigned STAT_W = 2;
endpackage

// File: rtl/kq_rst_sync.sv
module kq_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/kq_store.sv
module kq_store #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  input  logic             ovf_mode_i,
  output logic [CNT_W-1:0] count_o,
  output logic [DW-1:0]    head_o,
  output logic             logged_o,
  output logic             overflow_o
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty, full, do_pop, room, do_write, overwrite;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign do_pop    = pop_i & ~empty;
  // a pop in the same cycle frees a slot for the arriving event
  assign room      = ~full | do_pop;
  assign do_write  = push_i & (room | ovf_mode_i);
  assign overwrite = push_i & ~room & ovf_mode_i;

  always_comb begin
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (do_write)            wptr_d = ptr_inc(wptr_q);
    if (do_pop || overwrite) rptr_d = ptr_inc(rptr_q);
    case ({do_write & ~overwrite, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) mem[wptr_q] <= push_data_i;
  end

  assign head_o     = empty ? '0 : mem[rptr_q];
  assign count_o    = cnt_q;
  assign logged_o   = do_write;
  assign overflow_o = push_i & ~room;

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R5
  drop_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i && !ovf_mode_i) |=>
      (cnt_q == CNT_W'(DEPTH) && $stable(wptr_q) && $stable(rptr_q)));

  // R6
  overwrite_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i && ovf_mode_i) |=>
      (cnt_q == CNT_W'(DEPTH) && rptr_q != $past(rptr_q) && rptr_q == wptr_q));

  // R10
  push_pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !empty) |=> $stable(cnt_q));
endmodule

// File: rtl/kq_regs.sv
module kq_regs
  import kq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  input  logic              logged_i,
  input  logic              overflow_i,
  output kq_cfg_t           cfg_o,
  output logic              evt_flag_o,
  output logic              ovf_flag_o,
  output logic              irq_n_o
);
  kq_cfg_t cfg_q, cfg_d;
  logic    evt_q, evt_d, ovf_q, ovf_d;
  logic    evt_clr, ovf_clr;

  assign evt_clr = stat_we_i & clr_mask_i[0];
  assign ovf_clr = stat_we_i & clr_mask_i[1];

  always_comb begin
    cfg_d = cfg_we_i ? kq_cfg_t'(cfg_wdata_i) : cfg_q;
    // a new set in the same cycle wins over a clear
    evt_d = (evt_q & ~evt_clr) | (logged_i & cfg_q.evt_ie);
    ovf_d = (ovf_q & ~ovf_clr) | overflow_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      evt_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      evt_q <= evt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign evt_flag_o = evt_q;
  assign ovf_flag_o = ovf_q;
  assign irq_n_o    = ~((evt_q & cfg_q.evt_ie) | (ovf_q & cfg_q.ovf_ie));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_i |=> ovf_flag_o);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !ovf_clr) |=> ovf_flag_o);

  // R8
  evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_flag_o && !(logged_i && cfg_o.evt_ie)) |=> !evt_flag_o);

  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && ovf_clr && !logged_i && !overflow_i) |=> irq_n_o);
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
  import kq_pkg::*;
#(
  parameter int unsigned DEPTH       = 10,
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 5,
  parameter int unsigned CFG_ADDR    = 0,
  parameter int unsigned STAT_ADDR   = 1,
  parameter int unsigned CNT_ADDR    = 2,
  parameter int unsigned EVT_BASE    = 4,
  parameter int unsigned EVT_ALIASES = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [DW-1:0] ev_data,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          irq_n
);
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] EVT_LO = AW'(EVT_BASE);
  localparam logic [AW-1:0] EVT_HI = AW'(EVT_BASE + EVT_ALIASES - 1);

  logic             rst_sync_n;
  logic             rd, evt_hit, pop_req, cfg_we, stat_we;
  logic [CNT_W-1:0] count;
  logic [DW-1:0]    head;
  logic             logged, overflow, evt_flag, ovf_flag;
  kq_cfg_t          cfg;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             unused_wdata;

  kq_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign rd      = acc_en & ~acc_wr;
  assign evt_hit = (acc_addr >= EVT_LO) && (acc_addr <= EVT_HI);
  assign pop_req = rd & evt_hit;
  assign cfg_we  = acc_en & acc_wr & (acc_addr == AW'(CFG_ADDR));
  assign stat_we = acc_en & acc_wr & (acc_addr == AW'(STAT_ADDR));
  assign unused_wdata = ^acc_wdata[DW-1:CFG_W];

  kq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_i      (ev_valid),
    .push_data_i (ev_data),
    .pop_i       (pop_req),
    .ovf_mode_i  (cfg.ovf_mode),
    .count_o     (count),
    .head_o      (head),
    .logged_o    (logged),
    .overflow_o  (overflow)
  );

  kq_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (acc_wdata[CFG_W-1:0]),
    .stat_we_i   (stat_we),
    .clr_mask_i  (acc_wdata[STAT_W-1:0]),
    .logged_i    (logged),
    .overflow_i  (overflow),
    .cfg_o       (cfg),
    .evt_flag_o  (evt_flag),
    .ovf_flag_o  (ovf_flag),
    .irq_n_o     (irq_n)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd) begin
      if (evt_hit)                          rdata_d = head;
      else if (acc_addr == AW'(CFG_ADDR))   rdata_d = {{(DW-CFG_W){1'b0}}, cfg};
      else if (acc_addr == AW'(STAT_ADDR))  rdata_d = {{(DW-STAT_W){1'b0}}, ovf_flag, evt_flag};
      else if (acc_addr == AW'(CNT_ADDR))   rdata_d = {{(DW-CNT_W){1'b0}}, count};
      else                                  rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign acc_rdata = rdata_q;

  // R3
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop_req && count == '0) |=> (acc_rdata == '0 && count == '0));
endmodule

// File: tb/key_event_queue_test.sv
`timescale 1ns/1ps
module key_event_queue_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_valid;
  logic [7:0] ev_data;
  logic       acc_en, acc_wr;
  logic [4:0] acc_addr;
  logic [7:0] acc_wdata;
  logic [7:0] acc_rdata;
  logic       irq_n;

  always #2.5 clk = ~clk;

  key_event_queue uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_data(ev_data),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_n(irq_n)
  );

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t       sb_q[$];
  exp_t       mon_it;
  logic [7:0] mdl[$];
  logic       mode_m = 1'b0;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: compare each read result once the capturing edge has passed
  always @(posedge clk) begin
    if (acc_en && !acc_wr) begin
      mon_it = sb_q.pop_front();
      #1;
      chk8(acc_rdata, mon_it.val, mon_it.tag);
    end
  end

  task automatic model_push(input logic [7:0] d);
    if (mdl.size() < 10) mdl.push_back(d);
    else if (mode_m) begin
      void'(mdl.pop_front());
      mdl.push_back(d);
    end
  endtask

  function automatic logic [7:0] model_pop();
    if (mdl.size() == 0) return 8'h00;
    return mdl.pop_front();
  endfunction

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = 5'(a);
    sb_q.push_back('{exp, tag});
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic rd_evt(input int a, input string tag);
    logic [7:0] e;
    e = model_pop();
    rd(a, e, tag);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 5'(a); acc_wdata = d;
    if (a == 0) mode_m = d[2];
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic push_ev(input logic [7:0] d);
    @(negedge clk);
    ev_valid = 1'b1; ev_data = d;
    model_push(d);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic push_rd(input logic [7:0] d, input int a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    ev_valid = 1'b1; ev_data = d;
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = 5'(a);
    e = model_pop();
    model_push(d);
    sb_q.push_back('{e, tag});
    @(negedge clk);
    ev_valid = 1'b0; acc_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    n_chk++;
    if (irq_n !== exp) begin
      n_err++;
      $display("FAIL %s: irq_n got %0b expected %0b", tag, irq_n, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; ev_data = '0;
    acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq(1'b1, "R1 irq idle");
    rd(2, 8'h00, "R1 count after reset");
    rd(1, 8'h00, "R1 status after reset");
    rd(0, 8'h00, "R1 config after reset");

    // R3 empty read
    rd_evt(4, "R3 empty pop");
    rd(2, 8'h00, "R3 count stays 0");

    // R2/R4/R8/R9 basic logging with event enable
    wr(0, 8'h01);
    push_ev(8'h81);
    chk_irq(1'b0, "R9 irq on event flag");
    push_ev(8'h8C);
    push_ev(8'h01);
    rd(1, 8'h01, "R8 event flag set");
    rd(2, 8'h03, "R4 count three");
    rd_evt(4,  "R2 first alias");
    rd_evt(13, "R2 last alias");
    rd(2, 8'h01, "R4 count after pops");
    rd_evt(9,  "R2 mid alias");
    rd_evt(7,  "R3 drained pop");
    wr(1, 8'h01);
    chk_irq(1'b1, "R9 irq released by clear");
    rd(1, 8'h00, "R8 flag cleared");

    // R8 enable off: flag untouched
    wr(0, 8'h00);
    push_ev(8'h15);
    rd(1, 8'h00, "R8 no flag when disabled");
    chk_irq(1'b1, "R9 irq quiet when disabled");
    rd_evt(5, "R2 pop single");

    // R5 drop mode with overflow interrupt enabled
    wr(0, 8'h02);
    for (int i = 0; i < 10; i++) push_ev(8'(8'h80 + i));
    rd(2, 8'h0A, "R4 count full");
    rd(1, 8'h00, "R7 no overflow at exactly full");
    chk_irq(1'b1, "R9 irq quiet before overflow");
    push_ev(8'h7F);
    rd(1, 8'h02, "R7 overflow flag set");
    chk_irq(1'b0, "R9 irq on overflow");
    rd(2, 8'h0A, "R5 count held at 10");
    for (int i = 0; i < 10; i++) rd_evt(4 + i, "R5 stored events intact");
    rd_evt(6, "R5 dropped event absent");
    rd(1, 8'h02, "R7 overflow flag sticky");
    wr(1, 8'h02);
    rd(1, 8'h00, "R7 overflow flag cleared");

    // R6 overwrite mode
    wr(0, 8'h04);
    for (int i = 0; i < 12; i++) push_ev(8'(8'h14 + i));
    rd(2, 8'h0A, "R6 count stays 10");
    rd(1, 8'h02, "R7 overflow in overwrite mode");
    chk_irq(1'b1, "R9 overflow masked");
    for (int i = 0; i < 10; i++) rd_evt(4, "R6 oldest remaining order");
    rd(2, 8'h00, "R6 count drained");
    wr(1, 8'h03);

    // R10 simultaneous write and pop
    push_ev(8'hA1);
    push_ev(8'h22);
    push_rd(8'hB3, 5, "R10 pop during write");
    rd(2, 8'h02, "R10 count unchanged");
    rd_evt(11, "R10 next event");
    rd_evt(12, "R10 new event kept");

    // R10 full queue, drop mode, pop and write together
    wr(0, 8'h00);
    for (int i = 0; i < 10; i++) push_ev(8'(8'h30 + i));
    push_rd(8'hC4, 8, "R10 pop at full");
    rd(1, 8'h00, "R10 no overflow with pop");
    rd(2, 8'h0A, "R10 count still 10");
    for (int i = 0; i < 10; i++) rd_evt(10, "R10 order after full swap");

    // R11 readback and unmapped addresses
    wr(0, 8'hFD);
    rd(0, 8'h05, "R11 config readback");
    rd(3, 8'h00, "R11 unmapped 3");
    rd(14, 8'h00, "R11 unmapped 14");
    rd(31, 8'h00, "R11 unmapped 31");

    repeat (3) @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_err++;
      $display("FAIL R2 scoreboard: got %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule